// File: doc/BRIEF.md
# Prescaled Real-Time Alarm Timer

This block is a low-speed timer that runs on a 32.768 kHz slow clock. A 16-bit programmable divider turns the slow clock into periodic increment ticks. Each tick advances a 32-bit elapsed-time counter. When the counter steps onto a programmed alarm value, an alarm flag is raised. In a second source mode, the counter advances on an external one-pulse-per-second enable instead. The divider keeps running in that mode and still raises its own tick flag.

Software controls the block through four word registers, selected by `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | mode | read/write |
| 1 | alarm | read/write |
| 2 | counter | read-only |
| 3 | status | clears on read |

Read data is combinational from the registers. A status read clears the flags at the clock edge that ends the access. A single interrupt line combines the two flags, each through its own enable.

Top module: `rt_alarm_timer`

## Requirements
- R1: After reset the registers read as follows. Mode reads 0x00008000: divisor 32768, all other bits clear. Alarm reads 0xFFFFFFFF. Counter reads 0 and status reads 0. `irq` is low.
- R2: Mode register layout: bits [15:0] divisor, bit 16 halt, bit 17 restart, bit 18 alarm interrupt enable, bit 19 tick interrupt enable, bit 20 one-second source select. With a divisor N of 3 or more, the counter advances exactly once every N slow-clock cycles.
- R3: A divisor field of 0 gives one counter advance every 65536 slow-clock cycles.
- R4: A divisor write of 1 or 2 is stored as 3. It reads back as 3 and gives one advance every 3 cycles.
- R5: Writing the mode register with the restart bit set clears the divider and the counter at that write's edge. The restart bit always reads back as 0.
- R6: While the halt bit is set, the counter holds its value.
- R7: With the one-second source bit set, the counter advances only on cycles where `sec_pulse` is high. The divider still runs and still sets the tick flag (status bit 1).
- R8: The alarm flag (status bit 0) sets on the advance that brings the counter equal to the alarm register. It sets once per match, not again while the count is unchanged.
- R9: A status read returns both flags and clears them. A flag event in the same cycle as the clearing read wins, so the flag stays set.
- R10: `irq` is high exactly when (alarm flag AND alarm enable) OR (tick flag AND tick enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_pulse | input | 1 | One-cycle enable, once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when addressing status) |
| reg_addr | input | 2 | Register select: 0 mode, 1 alarm, 2 counter, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong divider count shows up at the counter readout within one divisor period. It appears as an early or late step, which the bench catches by sampling the counter one cycle before and one cycle after the expected advance. A flag register that clears too eagerly, or sets twice, shows on the very next status read. A lost same-cycle event makes the status read that follows return 0 where 1 is due. A stale halt or source-select setting shows as counter drift across an idle window of tens of cycles.

// File: rtl/rtt_pkg.sv
// Package: shared register addresses and flag indices for the alarm timer.
// Assumes a 32-bit register data path.
package rtt_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ADDR_MODE   = 2'd0,
        ADDR_ALARM  = 2'd1,
        ADDR_COUNT  = 2'd2,
        ADDR_STATUS = 2'd3
    } rtt_addr_e;

    localparam int FLAG_ALARM = 0;
    localparam int FLAG_TICK  = 1;
    localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/rtt_divider.sv
// Module: programmable slow-clock divider.
// Emits a one-cycle tick every `div` cycles while running; div==0 means 2**DIV_W.
// Assumes div is never 1 or 2 (the register stage sanitizes it).
module rtt_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last;

    // Terminal phase: all ones for a divisor of zero, else div-1.
    always_comb begin
        if (div == '0) last = '1;
        else           last = div - 1'b1;
    end

    assign tick = run && !restart && (phase_q >= last);

    // Phase counter: cleared by restart, wraps at the terminal phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= '0;
        else if (restart)  phase_q <= '0;
        else if (run) begin
            if (phase_q >= last) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
        end
    end

    p_tick_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q == '0));
    p_restart_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));
endmodule

// File: rtl/rtt_counter.sv
// Module: elapsed-time counter with alarm match detection.
// Advances by one on `step`, wraps at its width. It reports a match event on
// the step whose new value equals `alarm`. Assumes `step` is already gated by
// run and restart.
module rtt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count,
    output logic             match_evt
);
    logic [CNT_W-1:0] next_count;

    assign next_count = count + 1'b1;
    assign match_evt  = step && (next_count == alarm);

    // Count register: cleared by restart, incremented on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else if (step)    count <= next_count;
    end

    p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
    p_hold_without_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(count));
    p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/rtt_status.sv
// Module: sticky event flags with clear-on-read.
// A same-cycle event beats the clear. Assumes `clear` is a one-cycle strobe.
module rtt_status #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt,
    input  logic             clear,
    output logic [NFLAG-1:0] flag
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // One sticky flag: set by its event, cleared by a status read.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[g] <= 1'b0;
            else if (evt[g]) flag[g] <= 1'b1;
            else if (clear)  flag[g] <= 1'b0;
        end

        p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flag[g]);
        p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clear && !evt[g]) |=> !flag[g]);
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clear) |=> flag[g]);
    end
endmodule

// File: rtl/rt_alarm_timer.sv
// Module: top of the prescaled real-time alarm timer.
// Holds the mode and alarm registers, decodes register accesses and picks the
// counter source. It combines the flags into one interrupt.
// Assumes single-cycle read/write strobes on the slow clock domain.
module rt_alarm_timer #(
    parameter int DIV_W                 = 16,
    parameter int CNT_W                 = 32,
    parameter logic [DIV_W-1:0] DIV_RST = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_pulse,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    import rtt_pkg::*;

    localparam int HALT_B    = DIV_W;
    localparam int RESTART_B = DIV_W + 1;
    localparam int AIE_B     = DIV_W + 2;
    localparam int TIE_B     = DIV_W + 3;
    localparam int SEC_B     = DIV_W + 4;
    localparam int PAD_W     = REG_W - SEC_B - 1;

    logic [DIV_W-1:0] div_q;
    logic             halt_q, alm_ie_q, tick_ie_q, sec_src_q;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] count;
    logic             mode_wr, alarm_wr, status_rd, restart;
    logic             run, tick, step, match_evt;
    logic [NUM_FLAGS-1:0] evt, flag;
    logic [DIV_W-1:0] div_in;
    logic             unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[REG_W-1:SEC_B+1];

    assign mode_wr   = reg_wr && (reg_addr == ADDR_MODE);
    assign alarm_wr  = reg_wr && (reg_addr == ADDR_ALARM);
    assign status_rd = reg_rd && (reg_addr == ADDR_STATUS);
    assign restart   = mode_wr && reg_wdata[RESTART_B];
    assign run       = !halt_q;

    // Divisor sanitizer: the forbidden values 1 and 2 become 3.
    always_comb begin
        div_in = reg_wdata[DIV_W-1:0];
        if (div_in == DIV_W'(1) || div_in == DIV_W'(2)) div_in = DIV_W'(3);
    end

    // Mode register: divisor, halt, interrupt enables, source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= DIV_RST;
            halt_q    <= 1'b0;
            alm_ie_q  <= 1'b0;
            tick_ie_q <= 1'b0;
            sec_src_q <= 1'b0;
        end else if (mode_wr) begin
            div_q     <= div_in;
            halt_q    <= reg_wdata[HALT_B];
            alm_ie_q  <= reg_wdata[AIE_B];
            tick_ie_q <= reg_wdata[TIE_B];
            sec_src_q <= reg_wdata[SEC_B];
        end
    end

    // Alarm register: resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '1;
        else if (alarm_wr) alarm_q <= reg_wdata[CNT_W-1:0];
    end

    rtt_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .div(div_q), .tick(tick)
    );

    // Counter step source: divider tick or one-second enable.
    always_comb begin
        if (sec_src_q) step = run && !restart && sec_pulse;
        else           step = tick;
    end

    rtt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .alarm(alarm_q), .count(count), .match_evt(match_evt)
    );

    always_comb begin
        evt             = '0;
        evt[FLAG_ALARM] = match_evt;
        evt[FLAG_TICK]  = tick;
    end

    rtt_status #(.NFLAG(NUM_FLAGS)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clear(status_rd), .flag(flag)
    );

    assign irq = (flag[FLAG_ALARM] && alm_ie_q) || (flag[FLAG_TICK] && tick_ie_q);

    // Read multiplexer: restart bit always reads back as zero.
    always_comb begin
        case (reg_addr)
            ADDR_MODE:  reg_rdata = {{PAD_W{1'b0}}, sec_src_q, tick_ie_q, alm_ie_q,
                                     1'b0, halt_q, div_q};
            ADDR_ALARM: reg_rdata = REG_W'(alarm_q);
            ADDR_COUNT: reg_rdata = REG_W'(count);
            default:    reg_rdata = REG_W'(flag);
        endcase
    end

    p_div_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != DIV_W'(1)) && (div_q != DIV_W'(2)));
    p_alarm_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (count == $past(alarm_q)));
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_ie_q && !tick_ie_q) |-> !irq);
    p_halt_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !restart) |=> $stable(count));
endmodule

// File: tb/rt_alarm_timer_test.sv
`timescale 1ns/1ps
module rt_alarm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_pulse = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rt_alarm_timer uut (
        .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] mode_word(input int div, input bit halt,
        input bit rst, input bit aie, input bit tie, input bit sec);
        return {11'd0, sec, tie, aie, rst, halt, div[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset_r1();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        read_reg(2'd0, v); check("R1 mode", v, 32'h0000_8000);
        read_reg(2'd1, v); check("R1 alarm", v, 32'hFFFF_FFFF);
        read_reg(2'd2, v); check("R1 counter", v, 32'd0);
        read_reg(2'd3, v); check("R1 status", v, 32'd0);
    endtask

    task automatic t_div5_r2();
        logic [31:0] v;
        write_reg(2'd0, mode_word(5, 0, 1, 0, 0, 0));
        idle(4);
        read_reg(2'd2, v); check("R2 before first step", v, 32'd0);
        idle(4);
        read_reg(2'd2, v); check("R2 after one period", v, 32'd1);
        read_reg(2'd2, v); check("R2 after two periods", v, 32'd2);
    endtask

    task automatic t_div0_r3();
        logic [31:0] v;
        write_reg(2'd0, mode_word(0, 0, 1, 0, 0, 0));
        idle(65535);
        read_reg(2'd2, v); check("R3 before 65536", v, 32'd0);
        read_reg(2'd2, v); check("R3 at 65536", v, 32'd1);
    endtask

    task automatic t_forbidden_r4();
        logic [31:0] v;
        write_reg(2'd0, mode_word(1, 0, 0, 0, 0, 0));
        read_reg(2'd0, v); check("R4 div 1 stored as 3", v, 32'd3);
        write_reg(2'd0, mode_word(2, 0, 1, 0, 0, 0));
        read_reg(2'd0, v); check("R4 div 2 stored as 3, R5 restart reads 0", v, 32'd3);
        write_reg(2'd0, mode_word(2, 0, 1, 0, 0, 0));
        idle(2);
        read_reg(2'd2, v); check("R4 before step", v, 32'd0);
        read_reg(2'd2, v); check("R4 step every 3", v, 32'd1);
    endtask

    task automatic t_restart_r5();
        logic [31:0] v;
        write_reg(2'd0, mode_word(3, 0, 1, 0, 0, 0));
        idle(12);
        read_reg(2'd2, v); check("R5 counting before restart", v, 32'd4);
        write_reg(2'd0, mode_word(3, 0, 1, 0, 0, 0));
        read_reg(2'd2, v); check("R5 cleared by restart", v, 32'd0);
    endtask

    task automatic t_halt_r6();
        logic [31:0] v;
        write_reg(2'd0, mode_word(3, 0, 1, 0, 0, 0));
        idle(6);
        write_reg(2'd0, mode_word(3, 1, 0, 0, 0, 0));
        idle(20);
        read_reg(2'd2, v); check("R6 held while halted", v, 32'd2);
    endtask

    task automatic t_sec_r7();
        logic [31:0] v;
        write_reg(2'd0, mode_word(3, 0, 1, 0, 0, 1));
        read_reg(2'd3, v);
        idle(5);
        read_reg(2'd2, v); check("R7 divider ignored by counter", v, 32'd0);
        read_reg(2'd3, v); check("R7 tick flag still set", v & 32'h2, 32'h2);
        sec_pulse = 1'b1;
        @(negedge clk);
        sec_pulse = 1'b0;
        read_reg(2'd2, v); check("R7 one pulse one step", v, 32'd1);
        idle(10);
        read_reg(2'd2, v); check("R7 no step without pulse", v, 32'd1);
    endtask

    task automatic t_alarm_r8();
        logic [31:0] v;
        logic        irq_s;
        write_reg(2'd1, 32'd2);
        write_reg(2'd0, mode_word(3, 0, 1, 1, 0, 0));
        read_reg(2'd3, v);
        idle(4);
        irq_s = irq;
        read_reg(2'd3, v); check("R8 no alarm before match", v & 32'h1, 32'h0);
        check("R10 tick flag masked", {31'd0, irq_s}, 32'd0);
        #1 irq_s = irq;
        check("R10 alarm raises irq", {31'd0, irq_s}, 32'd1);
        read_reg(2'd3, v); check("R8 alarm on match", v & 32'h1, 32'h1);
        read_reg(2'd3, v); check("R8 alarm once per match", v & 32'h1, 32'h0);
        write_reg(2'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_clear_r9();
        logic [31:0] v;
        write_reg(2'd0, mode_word(3, 0, 1, 0, 0, 0));
        read_reg(2'd3, v);
        idle(1);
        read_reg(2'd3, v); check("R9 cleared by read", v, 32'd0);
        read_reg(2'd3, v); check("R9 event beats clear", v, 32'h2);
        read_reg(2'd3, v); check("R9 cleared after read", v, 32'd0);
    endtask

    task automatic t_tick_irq_r10();
        logic [31:0] v;
        write_reg(2'd0, mode_word(3, 0, 1, 0, 1, 0));
        read_reg(2'd3, v);
        #1 check("R10 irq low after clear", {31'd0, irq}, 32'd0);
        idle(3);
        #1 check("R10 tick raises irq", {31'd0, irq}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_div5_r2();
        t_div0_r3();
        t_forbidden_r4();
        t_restart_r5();
        t_halt_r6();
        t_sec_r7();
        t_alarm_r8();
        t_clear_r9();
        t_tick_irq_r10();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule